// File: doc/BRIEF.md
# Phase Mismatch Jump Controller

This block sits beside a script engine that runs block-move instructions on a parallel peripheral bus. When the bus protocol engine reports that the bus entered a phase the running instruction did not expect, the block decides what happens next. A two-bit control register sets the policy. With jumping off, the block raises a one-cycle interrupt and nothing else. With jumping on, it raises no interrupt. It captures the context of the interrupted move and has the FIFO either flushed (inbound moves) or cleared (outbound moves). It then writes back the residual byte count and the next buffer address. Last, it loads one of two programmable jump addresses into the script program counter.

The jump target can be chosen in two ways. One way keys on the wide-residue status flag. The other keys on the direction group of the phase encoded in the instruction, not on the phase seen on the bus. A byte left in the wide-residue holding register is never touched by the automatic drain, and software must flush it. The block therefore completes as soon as the FIFO reports empty. All inputs of a mismatch are captured in the cycle it is accepted. A mismatch strobe that arrives while a sequence is in progress is ignored.

Top module: `pmj_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and `irq`, `busy`, `wb_valid` and `pc_load` are low. This means mismatches raise interrupts and the target is chosen from the wide-residue flag.
- R2: With control bit 7 clear, a `mismatch` pulse sampled while idle drives `irq` high for exactly the next cycle. `busy`, `wb_valid` and `pc_load` stay low.
- R3: With control bit 7 set, a `mismatch` pulse sampled while idle never raises `irq`, and `busy` is high in the next cycle.
- R4: For an outbound move (`instr_dir_in` = 0: data-out, command or message-out), `clear_req` is high and `flush_req` is low from the cycle after acceptance until `fifo_empty` is sampled high.
- R5: For an inbound move (`instr_dir_in` = 1: data-in, status or message-in), `flush_req` is high and `clear_req` is low over the same drain window.
- R6: `wb_valid` is high for one cycle, in the cycle after `fifo_empty` is sampled high during the drain. In that cycle `wb_count` = `orig_count` − `xfer_count` modulo 2^CNT_W and `wb_addr` = `orig_addr` + `xfer_count` modulo 2^ADR_W. Bytes discarded by a clear are not counted.
- R7: `pc_load` is high for exactly the one cycle after `wb_valid`, and `busy` is low in the cycle after that.
- R8: With control bit 6 clear, `pc_value` equals `jmp_addr1` if `wide_resid` was 0 at acceptance and `jmp_addr2` if it was 1.
- R9: With control bit 6 set, `pc_value` equals `jmp_addr1` for outbound moves and `jmp_addr2` for inbound moves, whatever the value of `wide_resid`.
- R10: A `mismatch` pulse while `busy` is high raises no `irq`. It starts no second sequence and does not change the captured count, address or target.
- R11: Control register bits 5:0 read as 0 whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data: bit 7 jump enable, bit 6 direction-based target select |
| cfg_rdata | output | 8 | Control register readback |
| mismatch | input | 1 | One-cycle phase mismatch strobe |
| instr_dir_in | input | 1 | Direction group of the instruction phase, 1 = inbound |
| wide_resid | input | 1 | Wide-residue status flag |
| orig_count | input | CNT_W | Byte count of the interrupted move |
| orig_addr | input | ADR_W | Start address of the interrupted move |
| xfer_count | input | CNT_W | Bytes actually moved on the bus |
| jmp_addr1 | input | ADR_W | First programmable jump address |
| jmp_addr2 | input | ADR_W | Second programmable jump address |
| fifo_empty | input | 1 | FIFO reports empty or cleared |
| irq | output | 1 | One-cycle mismatch interrupt |
| busy | output | 1 | Jump sequence in progress |
| flush_req | output | 1 | Request to flush FIFO data out (inbound) |
| clear_req | output | 1 | Request to discard FIFO data (outbound) |
| wb_valid | output | 1 | Write-back strobe for count and address |
| wb_count | output | CNT_W | Residual byte count |
| wb_addr | output | ADR_W | Next buffer address |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | ADR_W | Jump target |

## Verification
Random mismatches draw the enable bit, the select bit, direction, wide-residue flag, counts, addresses, both jump targets and the drain length. Each result is compared with a bench model of residue, address and target choice. Mixing both select modes with both flag values and both directions shows whether the target follows the flag or the direction. It also shows whether the drain request matches the direction. Directed cases cover a zero transfer, a transfer that uses the full count, an address that wraps, an immediate drain, and a mismatch injected mid-drain with altered inputs, which would show up as changed results or a stray interrupt.

// File: rtl/pmj_pkg.sv
package pmj_pkg;
  localparam int CFG_W       = 8;
  localparam int CFG_EN_BIT  = 7;
  localparam int CFG_SEL_BIT = 6;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_UPDATE = 2'd2,
    ST_JUMP   = 2'd3
  } pmj_state_e;
endpackage

// File: rtl/pmj_cfg_reg.sv
module pmj_cfg_reg
  import pmj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             jmp_en,
  output logic             sel_dir
);
  logic en_q, sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (we) begin
      en_q  <= wdata[CFG_EN_BIT];
      sel_q <= wdata[CFG_SEL_BIT];
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[CFG_EN_BIT]  = en_q;
    rdata[CFG_SEL_BIT] = sel_q;
  end

  assign jmp_en  = en_q;
  assign sel_dir = sel_q;
endmodule

// File: rtl/pmj_calc.sv
module pmj_calc #(
  parameter int CNT_W = 24,
  parameter int ADR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             sel_dir,
  input  logic             dir_in,
  input  logic             wide_resid,
  input  logic [CNT_W-1:0] orig_count,
  input  logic [ADR_W-1:0] orig_addr,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic [ADR_W-1:0] jmp_addr1,
  input  logic [ADR_W-1:0] jmp_addr2,
  output logic [CNT_W-1:0] resid_count,
  output logic [ADR_W-1:0] next_addr,
  output logic [ADR_W-1:0] target,
  output logic             dir_in_q
);
  function automatic logic [CNT_W-1:0] residue(input logic [CNT_W-1:0] total,
                                               input logic [CNT_W-1:0] moved);
    return total - moved;
  endfunction

  function automatic logic [ADR_W-1:0] advance(input logic [ADR_W-1:0] base,
                                               input logic [CNT_W-1:0] moved);
    logic [ADR_W-1:0] ext;
    ext = ADR_W'(moved);
    return base + ext;
  endfunction

  function automatic logic pick_second(input logic by_dir, input logic inbound,
                                       input logic wres);
    return by_dir ? inbound : wres;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resid_count <= '0;
      next_addr   <= '0;
      target      <= '0;
      dir_in_q    <= 1'b0;
    end else if (capture) begin
      resid_count <= residue(orig_count, xfer_count);
      next_addr   <= advance(orig_addr, xfer_count);
      target      <= pick_second(sel_dir, dir_in, wide_resid) ? jmp_addr2 : jmp_addr1;
      dir_in_q    <= dir_in;
    end
  end
endmodule

// File: rtl/pmj_fsm.sv
module pmj_fsm
  import pmj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fifo_empty,
  output pmj_state_e state
);
  pmj_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_DRAIN;
      ST_DRAIN:  if (fifo_empty) nxt = ST_UPDATE;
      ST_UPDATE: nxt = ST_JUMP;
      ST_JUMP:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pmj_ctrl.sv
module pmj_ctrl
  import pmj_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int ADR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             mismatch,
  input  logic             instr_dir_in,
  input  logic             wide_resid,
  input  logic [CNT_W-1:0] orig_count,
  input  logic [ADR_W-1:0] orig_addr,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic [ADR_W-1:0] jmp_addr1,
  input  logic [ADR_W-1:0] jmp_addr2,
  input  logic             fifo_empty,
  output logic             irq,
  output logic             busy,
  output logic             flush_req,
  output logic             clear_req,
  output logic             wb_valid,
  output logic [CNT_W-1:0] wb_count,
  output logic [ADR_W-1:0] wb_addr,
  output logic             pc_load,
  output logic [ADR_W-1:0] pc_value
);
  logic       jmp_en, sel_dir, dir_in_q;
  logic       mm_accept, start_jump, start_irq, irq_q;
  pmj_state_e state;

  pmj_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .jmp_en(jmp_en), .sel_dir(sel_dir)
  );

  // events named for the checker
  assign mm_accept  = mismatch && (state == ST_IDLE);
  assign start_jump = mm_accept && jmp_en;
  assign start_irq  = mm_accept && !jmp_en;

  pmj_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_jump),
    .fifo_empty(fifo_empty), .state(state)
  );

  pmj_calc #(.CNT_W(CNT_W), .ADR_W(ADR_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .capture(start_jump), .sel_dir(sel_dir),
    .dir_in(instr_dir_in), .wide_resid(wide_resid),
    .orig_count(orig_count), .orig_addr(orig_addr), .xfer_count(xfer_count),
    .jmp_addr1(jmp_addr1), .jmp_addr2(jmp_addr2),
    .resid_count(wb_count), .next_addr(wb_addr), .target(pc_value),
    .dir_in_q(dir_in_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= start_irq;
  end

  assign irq       = irq_q;
  assign busy      = (state != ST_IDLE);
  assign flush_req = (state == ST_DRAIN) && dir_in_q;
  assign clear_req = (state == ST_DRAIN) && !dir_in_q;
  assign wb_valid  = (state == ST_UPDATE);
  assign pc_load   = (state == ST_JUMP);
endmodule

// File: rtl/pmj_chk.sv
module pmj_chk (
  input logic clk,
  input logic rst_n,
  input logic mismatch,
  input logic jmp_en,
  input logic busy,
  input logic irq,
  input logic flush_req,
  input logic clear_req,
  input logic fifo_empty,
  input logic wb_valid,
  input logic pc_load
);
  // R2
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mismatch && !jmp_en && !busy));

  // R2
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R3
  jump_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && jmp_en && !busy) |=> (!irq && (flush_req || clear_req)));

  // R4
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_req || clear_req) && !fifo_empty) |=> (flush_req || clear_req));

  // R6
  update_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past((flush_req || clear_req) && fifo_empty));

  // R7
  jump_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(wb_valid));

  // R7
  jump_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (!pc_load && !busy));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mismatch) |=> !irq);
endmodule

bind pmj_ctrl pmj_chk u_pmj_chk (
  .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .jmp_en(jmp_en),
  .busy(busy), .irq(irq), .flush_req(flush_req), .clear_req(clear_req),
  .fifo_empty(fifo_empty), .wb_valid(wb_valid), .pc_load(pc_load)
);

// File: tb/tb_pmj_ctrl.sv
module tb_pmj_ctrl;
  localparam int CNT_W = 24;
  localparam int ADR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic mismatch = 1'b0, instr_dir_in = 1'b0, wide_resid = 1'b0;
  logic [CNT_W-1:0] orig_count = '0, xfer_count = '0;
  logic [ADR_W-1:0] orig_addr = '0, jmp_addr1 = '0, jmp_addr2 = '0;
  logic fifo_empty = 1'b1;
  logic irq, busy, flush_req, clear_req, wb_valid, pc_load;
  logic [CNT_W-1:0] wb_count;
  logic [ADR_W-1:0] wb_addr, pc_value;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmj_ctrl #(.CNT_W(CNT_W), .ADR_W(ADR_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CNT_W-1:0] exp_count(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] x);
    logic [CNT_W:0] d;
    d = {1'b1, c} - {1'b0, x};
    return d[CNT_W-1:0];
  endfunction

  function automatic logic [ADR_W-1:0] exp_addr(input logic [ADR_W-1:0] a,
                                                input logic [CNT_W-1:0] x);
    logic [ADR_W:0] s;
    s = {1'b0, a} + {{(ADR_W+1-CNT_W){1'b0}}, x};
    return s[ADR_W-1:0];
  endfunction

  function automatic logic [ADR_W-1:0] exp_target(input bit sel, input bit dir,
      input bit wr, input logic [ADR_W-1:0] a1, input logic [ADR_W-1:0] a2);
    if (sel) return dir ? a2 : a1;   // R9 direction-based
    else     return wr ? a2 : a1;    // R8 flag-based
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_one(input bit en, input bit sel, input bit dir, input bit wr,
                         input logic [CNT_W-1:0] oc, input logic [ADR_W-1:0] oa,
                         input logic [CNT_W-1:0] xf, input logic [ADR_W-1:0] a1,
                         input logic [ADR_W-1:0] a2, input int delay, input bit inj);
    logic [CNT_W-1:0] ec;
    logic [ADR_W-1:0] ea, et;
    write_cfg({en, sel, 6'b0});
    ec = exp_count(oc, xf);
    ea = exp_addr(oa, xf);
    et = exp_target(sel, dir, wr, a1, a2);
    mismatch = 1'b1; instr_dir_in = dir; wide_resid = wr;
    orig_count = oc; orig_addr = oa; xfer_count = xf;
    jmp_addr1 = a1; jmp_addr2 = a2;
    fifo_empty = (delay == 0);
    @(negedge clk);
    mismatch = 1'b0;
    // scramble inputs: the captured context must hold (R10)
    orig_count = ~oc; orig_addr = ~oa; xfer_count = ~xf;
    jmp_addr1 = ~a1; jmp_addr2 = ~a2; wide_resid = ~wr; instr_dir_in = ~dir;
    if (!en) begin
      chk(irq == 1'b1, "R2 irq pulse", irq, 1);
      chk(busy == 1'b0 && wb_valid == 1'b0 && pc_load == 1'b0, "R2 no sequence",
          {busy, wb_valid, pc_load}, 0);
      @(negedge clk);
      chk(irq == 1'b0, "R2 irq one cycle", irq, 0);
      chk(busy == 1'b0, "R2 stays idle", busy, 0);
      fifo_empty = 1'b1;
      return;
    end
    chk(irq == 1'b0 && busy == 1'b1, "R3 jump no irq, busy", {irq, busy}, 2'b01);
    for (int k = 0; k < delay; k++) begin
      chk(flush_req == dir && clear_req == !dir,
          dir ? "R5 flush during drain" : "R4 clear during drain",
          {flush_req, clear_req}, {dir, !dir});
      chk(wb_valid == 1'b0, "R6 no write-back before empty", wb_valid, 0);
      if (inj && k == 0) mismatch = 1'b1;
      @(negedge clk);
      mismatch = 1'b0;
      if (inj) chk(irq == 1'b0, "R10 busy mismatch no irq", irq, 0);
    end
    if (delay == 0)
      chk(flush_req == dir && clear_req == !dir,
          dir ? "R5 flush request" : "R4 clear request",
          {flush_req, clear_req}, {dir, !dir});
    fifo_empty = 1'b1;
    @(negedge clk);
    chk(wb_valid == 1'b1 && flush_req == 1'b0 && clear_req == 1'b0,
        "R6 write-back strobe", {wb_valid, flush_req, clear_req}, 3'b100);
    chk(wb_count == ec, inj ? "R10 count kept" : "R6 residual count", wb_count, ec);
    chk(wb_addr == ea, inj ? "R10 addr kept" : "R6 next address", wb_addr, ea);
    chk(pc_load == 1'b0, "R7 no early load", pc_load, 0);
    @(negedge clk);
    chk(pc_load == 1'b1 && wb_valid == 1'b0, "R7 pc load", {pc_load, wb_valid}, 2'b10);
    chk(pc_value == et, sel ? "R9 target by direction" : "R8 target by flag",
        pc_value, et);
    @(negedge clk);
    chk(pc_load == 1'b0 && busy == 1'b0 && irq == 1'b0, "R7 back to idle",
        {pc_load, busy, irq}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 8'h00, "R1 cfg reset", cfg_rdata, 0);
    chk(irq == 0 && busy == 0 && wb_valid == 0 && pc_load == 0, "R1 outputs reset",
        {irq, busy, wb_valid, pc_load}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 8'h00 && busy == 1'b0, "R1 after release", cfg_rdata, 0);
    // R11 unused bits read zero
    write_cfg(8'hFF);
    chk(cfg_rdata == 8'hC0, "R11 unused bits", cfg_rdata, 8'hC0);
    write_cfg(8'h3F);
    chk(cfg_rdata == 8'h00, "R11 unused bits only", cfg_rdata, 8'h00);

    // directed corners
    run_one(0, 0, 0, 0, 24'd100, 32'h1000, 24'd10, 32'hA1, 32'hA2, 0, 0);      // R2
    run_one(1, 0, 0, 0, 24'd64, 32'h2000, 24'd0, 32'hB1, 32'hB2, 0, 0);        // R4 R8 zero xfer
    run_one(1, 0, 1, 1, 24'd64, 32'h2000, 24'd64, 32'hC1, 32'hC2, 2, 0);       // R5 R8 full count
    run_one(1, 1, 0, 1, 24'd80, 32'hFFFF_FFF0, 24'h20, 32'hD1, 32'hD2, 1, 0);  // R9 wrap, flag ignored
    run_one(1, 1, 1, 0, 24'd80, 32'h0, 24'd5, 32'hE1, 32'hE2, 3, 0);           // R9 inbound
    run_one(1, 0, 1, 0, 24'd200, 32'h4000, 24'd50, 32'hF1, 32'hF2, 3, 1);      // R10 injected

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [CNT_W-1:0] oc, xf;
      oc = CNT_W'($urandom);
      xf = CNT_W'($urandom % (32'(oc) + 1));
      run_one(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
              oc, $urandom, xf, $urandom, $urandom, $urandom % 5, ($urandom % 6) == 0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule